// File: doc/BRIEF.md
# Write-only I2C configuration register file

This block is a bus target that accepts configuration writes from a host controller over a two-wire I2C bus and keeps eighteen 8-bit control registers. These registers feed the rest of a picture-in-picture controller with mode bits, display positions, frame colours, a PLL divisor, wipe settings, six PWM levels and eight output port bits. The block only ever receives. It never returns data and never holds the clock low. It drives its data line low only to acknowledge a byte.

A write transfer has four parts. First comes a start condition. Next comes the address byte, which is the fixed 7-bit address 0100110 followed by a write bit of 0. The byte after that selects a register. Every later byte is stored in the selected register, and the selection then moves to the next register, wrapping from the last register back to the first. Both bus lines are sampled on the system clock through two-stage synchronizers, and every bus event is decoded from the synchronized copies. The system clock must run many times faster than SCL, which runs at up to 100 kHz.

The registers are presented as one flat vector. Register n occupies bits 8n+7 down to 8n.

Top module: `i2c_cfg_regfile`

## Requirements
- R1: After reset, register 00H reads 80H (the standby bit, bit 7, set), every other register reads 00H, and the data line is released (high).
- R2: An address byte of 0100110 followed by a write bit of 0 (byte value 4CH) is acknowledged: the data line is held low during the ninth clock.
- R3: Any other address byte, including 4DH (the matching address with the read bit), is not acknowledged. The bytes that follow are neither acknowledged nor stored until the next start condition.
- R4: The first byte after an acknowledged address loads the register pointer and is acknowledged. No register changes because of it.
- R5: Each later byte of the transfer is acknowledged and stored in the register at the pointer, and the pointer then increments by one.
- R6: Incrementing the pointer from 11H gives 00H, so a burst continues at register 00H.
- R7: Reserved bits are always stored as 0 whatever the written data: bit 7 of 03H, bits 7:5 of 05H, bits 7:6 of 07H and of 08H, and bit 7 of 0AH.
- R8: A repeated start in the middle of a transfer restarts address matching. Registers written before it keep their values, and the transfer that follows works normally.
- R9: A pointer byte above 11H selects register 00H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | 1 turns on the open-drain pull-down of the data line |
| cfg_regs | output | 144 | All registers; register n at bits 8n+7:8n |

## Verification
The hardest state to reach from the ports is a repeated start that arrives after several data bytes, while the pointer sits mid-register-map. The stimulus writes one register, issues the repeated start while SCL is high with no stop first, re-addresses a second register, and then confirms that both written values are present and the register between them is untouched. The pointer wrap and the ignore state after a mismatch need bursts that cross 11H and bytes clocked after a refused address. Each of these cases is set up explicitly, and every ninth-clock acknowledge is compared against a scoreboard entry queued by the driver.

// File: rtl/cfg_pkg.sv
// Package: shared constants, state encoding and per-register constants
// for the write-only configuration register file.
// Assumes an 8-bit register width and a fixed 7-bit bus address.
package cfg_pkg;
    parameter int         REG_COUNT = 18;
    parameter int         DATA_W    = 8;
    parameter logic [6:0] DEV_ADDR  = 7'b0100110;
    localparam int        PTR_W     = $clog2(REG_COUNT);
    localparam int        PTR_MAX   = REG_COUNT - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_DATA,
        ST_ACK,
        ST_SKIP
    } bus_state_t;

    // Bits that are reserved and must hold zero in each register.
    function automatic logic [DATA_W-1:0] rsv_mask(input int idx);
        case (idx)
            3:       return 8'h80;
            5:       return 8'hE0;
            7, 8:    return 8'hC0;
            10:      return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    // Value loaded by reset: register 0 starts with standby set.
    function automatic logic [DATA_W-1:0] reset_val(input int idx);
        return (idx == 0) ? 8'h80 : 8'h00;
    endfunction
endpackage

// File: rtl/cfg_sync_edge.sv
// Module: brings SCL and SDA into the clock domain through a synchronizer
// chain and decodes SCL edges plus start and stop conditions.
// Assumes the lines idle high and change far slower than clk.
module cfg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_p  <= scl_sh[STAGES-1];
            sda_p  <= sda_sh[STAGES-1];
        end
    end

    // Edge and bus-condition decode on the synchronized lines.
    always_comb begin
        scl_s     = scl_sh[STAGES-1];
        sda_s     = sda_sh[STAGES-1];
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        bus_start = scl_s & scl_p & sda_p & ~sda_s;
        bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/cfg_i2c_engine.sv
// Module: bus protocol engine. Shifts in bytes, matches the address,
// loads and advances the register pointer, issues writes and acknowledges.
// Assumes decoded events from cfg_sync_edge; never stretches SCL.
module cfg_i2c_engine
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    output logic              sda_low,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    bus_state_t        state;
    bus_state_t        after_ack;
    logic [DATA_W-1:0] shreg;
    logic [2:0]        bitcnt;
    logic              byte_full;
    logic [PTR_W-1:0]  ptr;
    logic              in_byte;

    // A byte is being received in these states.
    always_comb in_byte = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_DATA);

    // Protocol sequencing: bit shifting, byte decisions, ack drive and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            byte_full <= 1'b0;
            ptr       <= '0;
            sda_low   <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (bus_start) begin
                state     <= ST_ADDR;
                bitcnt    <= '0;
                byte_full <= 1'b0;
                sda_low   <= 1'b0;
            end else if (bus_stop) begin
                state     <= ST_IDLE;
                byte_full <= 1'b0;
                sda_low   <= 1'b0;
            end else if (in_byte && scl_rise && !byte_full) begin
                shreg  <= {shreg[DATA_W-2:0], sda_s};
                bitcnt <= bitcnt + 3'd1;
                if (bitcnt == 3'd7) byte_full <= 1'b1;
            end else if (in_byte && scl_fall && byte_full) begin
                byte_full <= 1'b0;
                state     <= ST_ACK;
                sda_low   <= 1'b1;
                case (state)
                    ST_ADDR: begin
                        if (shreg == {DEV_ADDR, 1'b0}) begin
                            after_ack <= ST_PTR;
                        end else begin
                            state   <= ST_SKIP;
                            sda_low <= 1'b0;
                        end
                    end
                    ST_PTR: begin
                        ptr       <= (shreg > DATA_W'(PTR_MAX)) ? '0 : shreg[PTR_W-1:0];
                        after_ack <= ST_DATA;
                    end
                    default: begin
                        wr_en     <= 1'b1;
                        wr_addr   <= ptr;
                        wr_data   <= shreg;
                        ptr       <= (ptr == PTR_W'(PTR_MAX)) ? '0 : ptr + 1'b1;
                        after_ack <= ST_DATA;
                    end
                endcase
            end else if (state == ST_ACK && scl_fall) begin
                sda_low <= 1'b0;
                state   <= after_ack;
                bitcnt  <= '0;
            end
        end
    end

    assert_ack_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low |-> (state == ST_ACK));
    assert_write_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_ACK && sda_low));
    assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_W'(PTR_MAX));
    assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!sda_low && !wr_en));
    assert_start_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (state == ST_ADDR && !sda_low));
endmodule

// File: rtl/cfg_reg_array.sv
// Module: the register storage. One register per address, written on a
// single-cycle strobe, with the reserved bits forced to zero on storage.
// Assumes wr_addr below REG_COUNT whenever wr_en is set.
module cfg_reg_array
    import cfg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [PTR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [REG_COUNT*DATA_W-1:0] regs_flat
);
    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        logic [DATA_W-1:0] r;

        // Holds one register; loads masked data when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= reset_val(i);
            end else if (wr_en && wr_addr == PTR_W'(i)) begin
                r <= wr_data & ~rsv_mask(i);
            end
        end

        assign regs_flat[i*DATA_W +: DATA_W] = r;

        assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (r & rsv_mask(i)) == '0);
        assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (r == reset_val(i)));
    end
endmodule

// File: rtl/i2c_cfg_regfile.sv
// Module: top of the write-only I2C configuration register file.
// Connects the line synchronizer, the protocol engine and the storage.
// Assumes an external open-drain pad: sda_pull_low=1 pulls SDA low.
module i2c_cfg_regfile
    import cfg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_in,
    input  logic                        sda_in,
    output logic                        sda_pull_low,
    output logic [REG_COUNT*DATA_W-1:0] cfg_regs
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              bus_start;
    logic              bus_stop;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [DATA_W-1:0] wr_data;

    cfg_sync_edge #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    cfg_i2c_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .sda_low   (sda_pull_low),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    cfg_reg_array u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .regs_flat (cfg_regs)
    );
endmodule

// File: tb/i2c_cfg_regfile_test.sv
// Bench: drives the bus as a host, queues expected acknowledges for a
// monitor to compare, and compares the registers with a bench-side model.
module i2c_cfg_regfile_test;
    localparam int NREG = 18;
    localparam int Q    = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_pull_low;
    logic [NREG*8-1:0] cfg_regs;
    logic sda_bus;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic  exp_ack;
        string tag;
    } ack_item_t;
    ack_item_t ackq[$];
    event ack_ev;

    logic [7:0] model [NREG];
    logic [7:0] wdat [32];

    always #4 clk = ~clk;

    assign sda_bus = ~(m_low | sda_pull_low);

    i2c_cfg_regfile uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (m_scl),
        .sda_in       (sda_bus),
        .sda_pull_low (sda_pull_low),
        .cfg_regs     (cfg_regs)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each acknowledge slot with the queued expectation.
    always @(ack_ev) begin
        if (ackq.size() == 0) begin
            check(1'b0, "ack-queue-empty", 32'(sda_bus), 32'hX);
        end else begin
            ack_item_t it;
            it = ackq.pop_front();
            check((sda_bus == 1'b0) == it.exp_ack, it.tag, 32'(!sda_bus), 32'(it.exp_ack));
        end
    end

    function automatic logic [7:0] mask_of(input int i);
        case (i)
            3:       return 8'h80;
            5:       return 8'hE0;
            7, 8:    return 8'hC0;
            10:      return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; m_scl = 1'b1; wq(2*Q);
        m_low = 1'b1; wq(2*Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        m_low = 1'b0; wq(Q);
        m_scl = 1'b1; wq(2*Q);
        m_low = 1'b1; wq(2*Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq(Q);
        m_scl = 1'b1; wq(2*Q);
        m_low = 1'b0; wq(2*Q);
    endtask

    // Driver: sends one byte and queues the expected acknowledge.
    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        ack_item_t it;
        it.exp_ack = exp_ack;
        it.tag = tag;
        ackq.push_back(it);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wq(Q);
            m_scl = 1'b1; wq(2*Q);
            m_scl = 1'b0; wq(Q);
        end
        m_low = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        -> ack_ev;
        wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    // Sends pointer and n data bytes of a transfer already addressed; updates model.
    task automatic send_body(input logic [7:0] ptr, input int n, input string tag);
        int p;
        send_byte(ptr, 1'b1, {tag, " R4 pointer ack"});
        p = (ptr > 8'h11) ? 0 : int'(ptr);
        for (int k = 0; k < n; k++) begin
            send_byte(wdat[k], 1'b1, {tag, " R5 data ack"});
            model[p] = wdat[k] & ~mask_of(p);
            p = (p == NREG-1) ? 0 : p + 1;
        end
    endtask

    task automatic full_write(input logic [7:0] ptr, input int n, input string tag);
        bus_start();
        send_byte(8'h4C, 1'b1, {tag, " R2 address ack"});
        send_body(ptr, n, tag);
        bus_stop();
    endtask

    task automatic check_regs(input string tag);
        bit ok = 1;
        int bad_i = 0;
        for (int i = 0; i < NREG; i++) begin
            if (ok && cfg_regs[i*8 +: 8] !== model[i]) begin
                ok = 0;
                bad_i = i;
            end
        end
        check(ok, $sformatf("%s reg%0d", tag, bad_i), 32'(cfg_regs[bad_i*8 +: 8]), 32'(model[bad_i]));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = (i == 0) ? 8'h80 : 8'h00;
        wq(5);
        rst_n = 1'b1;
        wq(5);

        // R1: reset state
        check_regs("R1 reset");
        check(sda_bus == 1'b1, "R1 sda released", 32'(sda_bus), 32'h1);

        // R2 R4 R5: basic burst from 01H
        wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
        full_write(8'h01, 3, "basic");
        check_regs("R5 burst 01H");

        // R4: pointer byte alone changes nothing
        full_write(8'h05, 0, "ptr-only");
        check_regs("R4 pointer only");

        // R7: all ones into 03H..0AH
        for (int k = 0; k < 8; k++) wdat[k] = 8'hFF;
        full_write(8'h03, 8, "rsv");
        check_regs("R7 reserved bits");

        // R6: wrap 10H,11H,00H,01H
        wdat[0] = 8'hA1; wdat[1] = 8'hA2; wdat[2] = 8'hA3; wdat[3] = 8'hA4;
        full_write(8'h10, 4, "wrap");
        check_regs("R6 wrap");

        // R3: wrong address, bytes after it ignored
        bus_start();
        send_byte(8'h4E, 1'b0, "R3 wrong address nack");
        send_byte(8'h02, 1'b0, "R3 ignored byte nack");
        send_byte(8'h55, 1'b0, "R3 ignored byte nack");
        bus_stop();
        check_regs("R3 wrong address");

        // R3: read direction refused
        bus_start();
        send_byte(8'h4D, 1'b0, "R3 read bit nack");
        send_byte(8'h66, 1'b0, "R3 ignored byte nack");
        bus_stop();
        check_regs("R3 read bit");

        // R8: repeated start mid transfer
        bus_start();
        send_byte(8'h4C, 1'b1, "R8 address ack");
        wdat[0] = 8'h5A;
        send_body(8'h0B, 1, "R8 first");
        bus_rstart();
        send_byte(8'h4C, 1'b1, "R8 readdress ack");
        wdat[0] = 8'h7E; wdat[1] = 8'h3C;
        send_body(8'h0D, 2, "R8 second");
        bus_stop();
        check_regs("R8 repeated start");

        // R8: repeated start then wrong address keeps registers
        bus_start();
        send_byte(8'h4C, 1'b1, "R8 address ack");
        wdat[0] = 8'h81;
        send_body(8'h11, 1, "R8 third");
        bus_rstart();
        send_byte(8'h20, 1'b0, "R8 wrong readdress nack");
        send_byte(8'h99, 1'b0, "R8 ignored byte nack");
        bus_stop();
        check_regs("R8 restart then mismatch");

        // R9: pointer above 11H selects 00H
        wdat[0] = 8'h99;
        full_write(8'h40, 1, "R9");
        check_regs("R9 pointer clamp");

        check(ackq.size() == 0, "R2 all acks observed", 32'(ackq.size()), 32'h0);
        check(sda_bus == 1'b1, "R1 sda idle after traffic", 32'(sda_bus), 32'h1);
        summary();
    end
endmodule